// File: doc/BRIEF.md
# Per-Port Auto-Partition Controller

This block decides, for a single repeater port, whether that port is cut off from the rest of the repeater. It watches four indications, all sampled only on cycles where a bit-time strobe is high: collision present, the port transmitting, the port receiving, and the strobe itself. When the port misbehaves, the block raises an `isolated` flag. The repeater core then stops forwarding frames from that port.

Two faults isolate the port. The first is a collision that stays present for a long unbroken stretch of bit times. The second is a run of consecutive transmit attempts to the port that each saw a collision. A transmit attempt is a maximal run of strobed bit times with transmit active. The attempt counts as collided if collision was present on any of those bit times.

An isolated port is reconnected once it carries an activity that is clean and long enough. An activity is a maximal run of strobed bit times with transmit or receive active. The activity is judged when it ends. One instance is placed per port, and the instances share no state.

Top module: `port_isolation_ctrl`

## Requirements
- R1: After reset `isolated` is 0 and every internal count is zero, so a collision lasting `LONG_COLL_TICKS-1` bit times right after reset does not isolate the port.
- R2: When collision is present on `LONG_COLL_TICKS` consecutive strobed bit times, `isolated` is 1 from the clock edge that samples the last of them.
- R3: A strobed bit time without collision clears the unbroken-collision count, so shorter collisions never add up.
- R4: When `COLL_RUN_LIMIT` consecutive transmit attempts are collided, `isolated` is 1 from the clock edge that samples the end of the last attempt. That end is the first strobed bit time with transmit low.
- R5: A transmit attempt that ends without a collision resets the consecutive-collided-attempt count to zero.
- R6: An isolated port returns `isolated` to 0 at the clock edge that samples the end of an activity. That activity must have lasted more than `CLEAN_MIN_TICKS` strobed bit times, with no collision on any of them.
- R7: An activity that had a collision on any of its bit times, or that lasted `CLEAN_MIN_TICKS` bit times or fewer, leaves the port isolated. The next activity is then timed from zero.
- R8: Inputs are only acted on when `bit_tick` is 1. On all other cycles `isolated` holds and no count advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | Bit-time strobe; inputs are sampled when high |
| coll_in | input | 1 | Collision present on this port |
| tx_act | input | 1 | Repeater is transmitting to this port |
| rx_act | input | 1 | Port is receiving |
| isolated | output | 1 | Port is partitioned |

## Verification
The bench builds the block with `LONG_COLL_TICKS=8`, `COLL_RUN_LIMIT=4` and `CLEAN_MIN_TICKS=6`. These small values let it sweep every collision length from 1 to 10 bit times, every reconnect activity length from 1 to 10, and every count of collided attempts from 1 to 6. Each sweep runs from a fresh reset, so the exact threshold edges of R2, R4 and R6 are hit on both sides. A strobe held low between bit times, with collision held high, exercises R8. A run broken by one clean attempt exercises R5.

// File: rtl/port_iso_pkg.sv
package port_iso_pkg;

    // Width needed to hold values 0..max_val (at least one bit).
    function automatic int cnt_width(input int max_val);
        int w;
        w = $clog2(max_val + 1);
        if (w < 1) w = 1;
        return w;
    endfunction

    // Registered state of the top-level isolation flag.
    typedef struct packed {
        logic isolated;
    } iso_state_t;

endpackage

// File: rtl/long_coll_timer.sv
module long_coll_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic coll,
    output logic fire
);
    localparam int W = port_iso_pkg::cnt_width(LIMIT);

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (tick) begin
            if (coll) begin
                if (st_q.cnt == W'(LIMIT - 1)) fire = 1'b1;
                if (st_q.cnt != W'(LIMIT)) st_d.cnt = st_q.cnt + W'(1);
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/attempt_run_tracker.sv
module attempt_run_tracker #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic tx,
    input  logic coll,
    output logic fire
);
    localparam int W = port_iso_pkg::cnt_width(LIMIT);

    typedef struct packed {
        logic         tx_prev;
        logic         hit;
        logic [W-1:0] run;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (tick) begin
            st_d.tx_prev = tx;
            if (tx) begin
                st_d.hit = (st_q.tx_prev ? st_q.hit : 1'b0) | coll;
            end else if (st_q.tx_prev) begin
                // attempt just ended
                st_d.hit = 1'b0;
                if (st_q.hit) begin
                    if (st_q.run == W'(LIMIT - 1)) begin
                        fire       = 1'b1;
                        st_d.run   = '0;
                    end else begin
                        st_d.run   = st_q.run + W'(1);
                    end
                end else begin
                    st_d.run = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/clean_activity_timer.sv
module clean_activity_timer #(
    parameter int MIN_LEN = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic act,
    input  logic coll,
    output logic qualified
);
    localparam int SAT = MIN_LEN + 1;
    localparam int W   = port_iso_pkg::cnt_width(SAT);

    typedef struct packed {
        logic         act_prev;
        logic         dirty;
        logic [W-1:0] len;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        qualified = 1'b0;
        if (tick) begin
            st_d.act_prev = act;
            if (act) begin
                if (coll) begin
                    st_d.dirty = 1'b1;
                    st_d.len   = '0;
                end else if (!st_q.dirty && st_q.len != W'(SAT)) begin
                    st_d.len = st_q.len + W'(1);
                end
            end else begin
                if (st_q.act_prev && !st_q.dirty && st_q.len == W'(SAT))
                    qualified = 1'b1;
                st_d.dirty = 1'b0;
                st_d.len   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/port_isolation_ctrl.sv
module port_isolation_ctrl #(
    parameter int LONG_COLL_TICKS = 1024,
    parameter int COLL_RUN_LIMIT  = 32,
    parameter int CLEAN_MIN_TICKS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic coll_in,
    input  logic tx_act,
    input  logic rx_act,
    output logic isolated
);
    import port_iso_pkg::*;

    logic long_fire, run_fire, clean_done;
    iso_state_t st_d, st_q;

    long_coll_timer #(.LIMIT(LONG_COLL_TICKS)) u_long (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (bit_tick),
        .coll (coll_in),
        .fire (long_fire)
    );

    attempt_run_tracker #(.LIMIT(COLL_RUN_LIMIT)) u_run (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (bit_tick),
        .tx   (tx_act),
        .coll (coll_in),
        .fire (run_fire)
    );

    clean_activity_timer #(.MIN_LEN(CLEAN_MIN_TICKS)) u_clean (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (bit_tick),
        .act      (tx_act | rx_act),
        .coll     (coll_in),
        .qualified(clean_done)
    );

    always_comb begin
        st_d = st_q;
        if (long_fire || run_fire)              st_d.isolated = 1'b1;
        else if (st_q.isolated && clean_done)   st_d.isolated = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign isolated = st_q.isolated;
endmodule

// File: rtl/port_iso_checker.sv
module port_iso_checker #(
    parameter int LONG_COLL_TICKS = 1024
) (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic coll_in,
    input logic tx_act,
    input logic rx_act,
    input logic isolated
);
    localparam int W = port_iso_pkg::cnt_width(LONG_COLL_TICKS);
    logic [W-1:0] seen;

    always_ff @(posedge clk) begin
        if (!rst_n) seen <= '0;
        else if (bit_tick) begin
            if (!coll_in)                          seen <= '0;
            else if (seen != W'(LONG_COLL_TICKS))  seen <= seen + W'(1);
        end
    end

    // R2
    long_coll_isolates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && coll_in && seen == W'(LONG_COLL_TICKS - 1)) |=> isolated);

    // R8
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(isolated));

    // R8
    rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isolated) |-> $past(bit_tick));

    // R6
    reconnect_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(isolated) |-> $past(bit_tick && !tx_act && !rx_act && !coll_in));
endmodule

bind port_isolation_ctrl port_iso_checker #(.LONG_COLL_TICKS(LONG_COLL_TICKS)) u_iso_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_tick(bit_tick),
    .coll_in (coll_in),
    .tx_act  (tx_act),
    .rx_act  (rx_act),
    .isolated(isolated)
);

// File: tb/test_port_isolation_ctrl.sv
`timescale 1ns/1ps
module test_port_isolation_ctrl;
    localparam int LONG  = 8;
    localparam int RUN   = 4;
    localparam int CLEAN = 6;

    logic clk = 1'b0;
    logic rst_n, bit_tick, coll_in, tx_act, rx_act, isolated;
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #10 clk = ~clk;

    port_isolation_ctrl #(
        .LONG_COLL_TICKS(LONG),
        .COLL_RUN_LIMIT (RUN),
        .CLEAN_MIN_TICKS(CLEAN)
    ) i_port_isolation_ctrl (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .coll_in(coll_in),
        .tx_act(tx_act), .rx_act(rx_act), .isolated(isolated)
    );

    task automatic check(input string req, input logic exp);
        n_checks++;
        if (isolated !== exp) begin
            n_fail++;
            $display("FAIL %s: isolated=%b expected=%b", req, isolated, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bit_tick = 1'b0; coll_in = 1'b0; tx_act = 1'b0; rx_act = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one strobed bit time followed by one unstrobed cycle
    task automatic step(input logic c, input logic t, input logic r);
        coll_in = c; tx_act = t; rx_act = r; bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic collided_attempt();
        step(1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic isolate_by_long();
        for (int i = 0; i < LONG; i++) step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        // R1: reset state
        do_reset();
        check("R1", 1'b0);
        for (int i = 0; i < LONG - 1; i++) step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check("R1", 1'b0);

        // R2: sweep collision lengths
        for (int len = 1; len <= LONG + 2; len++) begin
            do_reset();
            for (int i = 0; i < len; i++) step(1'b1, 1'b0, 1'b0);
            check("R2", len >= LONG);
            step(1'b0, 1'b0, 1'b0);
            check("R2", len >= LONG);
        end

        // R3: two shorter collisions separated by one clean bit time
        do_reset();
        for (int i = 0; i < LONG - 1; i++) step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < LONG - 1; i++) step(1'b1, 1'b0, 1'b0);
        check("R3", 1'b0);
        step(1'b1, 1'b0, 1'b0);
        check("R3", 1'b1);

        // R8: collision held without strobe does not count
        do_reset();
        coll_in = 1'b1;
        repeat (3 * LONG) @(negedge clk);
        check("R8", 1'b0);
        for (int i = 0; i < LONG - 1; i++) step(1'b1, 1'b0, 1'b0);
        check("R8", 1'b0);
        // R8: once isolated, clean activity without strobe has no effect
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        coll_in = 1'b0; rx_act = 1'b1;
        repeat (CLEAN + 3) @(negedge clk);
        rx_act = 1'b0;
        repeat (3) @(negedge clk);
        check("R8", 1'b1);

        // R4: sweep number of collided attempts
        for (int n = 1; n <= RUN + 2; n++) begin
            do_reset();
            for (int k = 0; k < n; k++) collided_attempt();
            check("R4", n >= RUN);
        end

        // R5: clean attempt breaks the run
        do_reset();
        for (int k = 0; k < RUN - 1; k++) collided_attempt();
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        for (int k = 0; k < RUN - 1; k++) collided_attempt();
        check("R5", 1'b0);
        collided_attempt();
        check("R5", 1'b1);

        // R6/R7: sweep reconnect activity lengths
        for (int len = 1; len <= CLEAN + 4; len++) begin
            do_reset();
            isolate_by_long();
            check("R6", 1'b1);
            for (int i = 0; i < len; i++) step(1'b0, 1'b0, 1'b1);
            step(1'b0, 1'b0, 1'b0);
            check(len > CLEAN ? "R6" : "R7", !(len > CLEAN));
        end

        // R7: long activity with a collision inside stays isolated
        do_reset();
        isolate_by_long();
        for (int i = 0; i < CLEAN + 4; i++) step(i == 2, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        check("R7", 1'b1);
        // R7: short activity, then timer restarts from zero
        for (int i = 0; i < CLEAN; i++) step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check("R7", 1'b1);
        // R6: transmit activity long enough reconnects
        for (int i = 0; i <= CLEAN; i++) step(1'b0, 1'b1, 1'b0);
        check("R6", 1'b1);
        step(1'b0, 1'b0, 1'b0);
        check("R6", 1'b0);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule